// File: doc/BRIEF.md
# Aperture Page Remapping Table

This block remaps addresses that fall inside a fixed input window (the aperture) onto physical memory, one 4 KiB page at a time. It keeps one page entry per aperture page. Each entry carries a valid flag and a physical page frame. A lookup port takes an input address and, one clock later, returns the remapped physical address or a fault.

Software never addresses the table directly. It reaches the table through three words of a register window. A control word switches remapping on or off. A selector word takes an input address and picks the page entry that address belongs to. A data word writes or reads the picked entry. With remapping switched off, every lookup faults, so the table can be saved or rebuilt while no client can use a stale mapping. Reading the control word returns its current value, which lets software confirm that its earlier writes have landed.

The aperture base and the page count are parameters. Reset clears every entry to invalid and leaves remapping switched off.

Top module: `aperture_remap_table`

## Requirements
- R1: After reset, remapping is off and every entry reads back as 0. `resp_valid`, `resp_addr`, `resp_fault` and `reg_rdata` are all 0.
- R2: A write to word 0 (control) sets the enable to `reg_wdata[0]`. A read of word 0 returns `{31'b0, enable}`.
- R3: A write to word 1 (selector) whose data lies in [BASE, BASE + PAGES*4096) selects page (data - BASE) >> 12. Any other write to word 1 leaves the selection unchanged. A read of word 1 returns BASE + page*4096.
- R4: A write to word 2 (entry data) stores bit 31 as the valid flag and bits 30:12 as the frame into the selected entry. A read of word 2 returns the selected entry with bits 11:0 as zero.
- R5: `reg_rdata` carries the read result in the cycle after `reg_rd` and is 0 in every other cycle. Word 3 reads as 0, and writes to word 3 change nothing.
- R6: `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high.
- R7: A lookup that is enabled, in the aperture and on a valid entry returns `resp_fault`=0 and `resp_addr` = {1'b0, frame, req_addr[11:0]}.
- R8: With remapping off, every lookup returns `resp_fault`=1 and `resp_addr`=0.
- R9: A lookup address below BASE, or at or above BASE + PAGES*4096, returns `resp_fault`=1 and `resp_addr`=0.
- R10: A lookup on an entry whose valid flag is clear returns `resp_fault`=1 and `resp_addr`=0.
- R11: A lookup issued in the same cycle as an entry-data write sees the old entry. A lookup issued in the next cycle sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register window write strobe |
| reg_rd | input | 1 | Register window read strobe |
| reg_word | input | 2 | Window word index: 0 control, 1 selector, 2 entry data, 3 unused |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Lookup input address |
| resp_valid | output | 1 | Lookup response strobe |
| resp_addr | output | 32 | Remapped physical address, 0 on fault |
| resp_fault | output | 1 | Lookup fault flag |

## Verification
A corrupted table entry stays hidden until a lookup lands on its page or software reads it back through the data word. Either one exposes it one cycle later. A wrong enable bit or page selection shows up at once: the next control or selector read reports it, and so does the fault flag of the next lookup. The bench therefore mixes dense read-backs with lookups that cluster around the aperture edges and around recently written pages, so that wrong internal state reaches the ports within a few cycles.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int FRAME_MSB  = 30;
    localparam int FRAME_W    = FRAME_MSB - PAGE_SHIFT + 1;

    typedef struct packed {
        logic               valid;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    typedef enum logic [1:0] {
        WIN_CFG  = 2'd0,
        WIN_SEL  = 2'd1,
        WIN_DATA = 2'd2,
        WIN_NONE = 2'd3
    } win_reg_e;

    function automatic logic [31:0] pte_to_word(input pte_t p);
        return {p.valid, p.frame, {PAGE_SHIFT{1'b0}}};
    endfunction
endpackage

// File: rtl/remap_range.sv
module remap_range
    import remap_pkg::*;
#(
    parameter logic [31:0] BASE  = 32'h4000_0000,
    parameter int          PAGES = 64,
    parameter int          IDX_W = 6
) (
    input  logic [31:0]      addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [31:0] page;

    always_comb begin
        page = (addr - BASE) >> PAGE_SHIFT;
        hit  = (addr >= BASE) && (page < 32'(PAGES));
        idx  = page[IDX_W-1:0];
    end
endmodule

// File: rtl/remap_store.sv
module remap_store
    import remap_pkg::*;
#(
    parameter int PAGES = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  pte_t             wpte,
    input  logic [IDX_W-1:0] ridx_a,
    output pte_t             rpte_a,
    input  logic [IDX_W-1:0] ridx_b,
    output pte_t             rpte_b
);
    pte_t [PAGES-1:0] tab_d, tab_q;

    for (genvar g = 0; g < PAGES; g++) begin : g_entry
        assign tab_d[g] = (we && (32'(widx) == g)) ? wpte : tab_q[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    always_comb begin
        rpte_a = (32'(ridx_a) < 32'(PAGES)) ? tab_q[ridx_a] : '0;
        rpte_b = (32'(ridx_b) < 32'(PAGES)) ? tab_q[ridx_b] : '0;
    end
endmodule

// File: rtl/remap_window.sv
module remap_window
    import remap_pkg::*;
#(
    parameter logic [31:0] BASE  = 32'h4000_0000,
    parameter int          IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_word,
    input  logic             wr_cfg,
    input  logic             sel_hit,
    input  logic [IDX_W-1:0] sel_new,
    input  pte_t             cur_pte,
    output logic             cfg_en,
    output logic [IDX_W-1:0] sel_idx,
    output logic             tab_we,
    output logic [31:0]      reg_rdata
);
    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] sel;
        logic [31:0]      rdata;
    } win_st_t;

    win_st_t  st_d, st_q;
    win_reg_e word_e;

    assign word_e = win_reg_e'(reg_word);

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (reg_rd) begin
            case (word_e)
                WIN_CFG:  st_d.rdata = {31'b0, st_q.en};
                WIN_SEL:  st_d.rdata = BASE + (32'(st_q.sel) << PAGE_SHIFT);
                WIN_DATA: st_d.rdata = pte_to_word(cur_pte);
                default:  st_d.rdata = '0;
            endcase
        end
        if (reg_wr) begin
            case (word_e)
                WIN_CFG: st_d.en = wr_cfg;
                WIN_SEL: if (sel_hit) st_d.sel = sel_new;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_en    = st_q.en;
    assign sel_idx   = st_q.sel;
    assign tab_we    = reg_wr && (word_e == WIN_DATA);
    assign reg_rdata = st_q.rdata;
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup
    import remap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [PAGE_SHIFT-1:0] req_lo,
    input  logic                  in_aperture,
    input  logic                  enable,
    input  pte_t                  pte,
    output logic                  resp_valid,
    output logic [31:0]           resp_addr,
    output logic                  resp_fault
);
    typedef struct packed {
        logic        vld;
        logic [31:0] addr;
        logic        fault;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d.vld   = req_valid;
        rsp_d.addr  = '0;
        rsp_d.fault = 1'b0;
        if (req_valid) begin
            if (enable && in_aperture && pte.valid) rsp_d.addr = {1'b0, pte.frame, req_lo};
            else                                    rsp_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign resp_valid = rsp_q.vld;
    assign resp_addr  = rsp_q.addr;
    assign resp_fault = rsp_q.fault;
endmodule

// File: rtl/aperture_remap_table.sv
module aperture_remap_table
    import remap_pkg::*;
#(
    parameter logic [31:0] BASE  = 32'h4000_0000,
    parameter int          PAGES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_word,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        resp_valid,
    output logic [31:0] resp_addr,
    output logic        resp_fault
);
    localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1;

    logic             cfg_en;
    logic [IDX_W-1:0] sel_idx;
    logic             sel_hit;
    logic [IDX_W-1:0] sel_new;
    logic             req_hit;
    logic [IDX_W-1:0] req_idx;
    logic             tab_we;
    pte_t             sel_pte;
    pte_t             req_pte;
    pte_t             wr_pte;

    assign wr_pte.valid = reg_wdata[31];
    assign wr_pte.frame = reg_wdata[FRAME_MSB:PAGE_SHIFT];

    remap_range #(.BASE(BASE), .PAGES(PAGES), .IDX_W(IDX_W)) u_sel_range (
        .addr(reg_wdata), .hit(sel_hit), .idx(sel_new)
    );

    remap_range #(.BASE(BASE), .PAGES(PAGES), .IDX_W(IDX_W)) u_req_range (
        .addr(req_addr), .hit(req_hit), .idx(req_idx)
    );

    remap_window #(.BASE(BASE), .IDX_W(IDX_W)) u_window (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_word(reg_word),
        .wr_cfg(reg_wdata[0]), .sel_hit(sel_hit), .sel_new(sel_new),
        .cur_pte(sel_pte), .cfg_en(cfg_en), .sel_idx(sel_idx),
        .tab_we(tab_we), .reg_rdata(reg_rdata)
    );

    remap_store #(.PAGES(PAGES), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(tab_we), .widx(sel_idx), .wpte(wr_pte),
        .ridx_a(sel_idx), .rpte_a(sel_pte),
        .ridx_b(req_idx), .rpte_b(req_pte)
    );

    remap_lookup u_lookup (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_lo(req_addr[PAGE_SHIFT-1:0]),
        .in_aperture(req_hit), .enable(cfg_en), .pte(req_pte),
        .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_fault(resp_fault)
    );
endmodule

// File: rtl/remap_checker.sv
module remap_checker #(
    parameter logic [31:0] BASE  = 32'h4000_0000,
    parameter int          PAGES = 64,
    parameter int          IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_word,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             req_valid,
    input logic [31:0]      req_addr,
    input logic             resp_valid,
    input logic [31:0]      resp_addr,
    input logic             resp_fault,
    input logic             cfg_en,
    input logic [IDX_W-1:0] sel_idx
);
    localparam logic [32:0] END_A = {1'b0, BASE} + 33'(PAGES) * 33'd4096;

    assert_resp_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    assert_no_spurious_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    assert_fault_zero_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (resp_valid && resp_addr == 32'h0));
    assert_off_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_en) |=> resp_fault);
    assert_below_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr < BASE) |=> resp_fault);
    assert_above_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && {1'b0, req_addr} >= END_A) |=> resp_fault);
    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_word == 2'd0) |=> (cfg_en == $past(reg_wdata[0])));
    assert_sel_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_word == 2'd1 && reg_wdata < BASE) |=> (sel_idx == $past(sel_idx)));
    assert_rdata_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == 32'h0));
endmodule

bind aperture_remap_table remap_checker #(.BASE(BASE), .PAGES(PAGES), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_word(reg_word),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_fault(resp_fault),
    .cfg_en(cfg_en), .sel_idx(sel_idx)
);

// File: tb/sim_aperture_remap_table.sv
module sim_aperture_remap_table;
    localparam logic [31:0] BASE  = 32'h4000_0000;
    localparam int          PAGES = 64;
    localparam longint      ENDA  = longint'(BASE) + longint'(PAGES) * 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_word = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        resp_valid;
    logic [31:0] resp_addr;
    logic        resp_fault;

    always #5 clk = ~clk;

    aperture_remap_table #(.BASE(BASE), .PAGES(PAGES)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_fault(resp_fault)
    );

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    bit          m_en;
    int          m_sel;
    logic [31:0] m_tab [PAGES];
    int          prev_wr_pg, cur_wr_pg, pg;
    longint      a;
    logic        exp_rv, exp_rf;
    logic [31:0] exp_ra, exp_rd;
    string       tag_l, tag_r;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_sel = 0; prev_wr_pg = -1;
            foreach (m_tab[i]) m_tab[i] = '0;
            exp_rv = 0; exp_rf = 0; exp_ra = '0; exp_rd = '0;
            tag_l = "R1"; tag_r = "R1";
        end else begin
            exp_rv = req_valid; exp_rf = 0; exp_ra = '0; tag_l = "R6";
            if (req_valid) begin
                a = longint'(req_addr);
                if (a < longint'(BASE) || a >= ENDA) begin
                    exp_rf = 1; tag_l = "R9";
                end else begin
                    pg = int'((a - longint'(BASE)) >>> 12);
                    if (!m_en) begin
                        exp_rf = 1; tag_l = "R8";
                    end else if (!m_tab[pg][31]) begin
                        exp_rf = 1; tag_l = "R10";
                    end else begin
                        exp_ra = {1'b0, m_tab[pg][30:12], req_addr[11:0]}; tag_l = "R7";
                    end
                    if (pg == prev_wr_pg || (reg_wr && reg_word == 2'd2 && pg == m_sel)) tag_l = "R11";
                end
            end
            exp_rd = '0; tag_r = "R5";
            if (reg_rd) begin
                case (reg_word)
                    2'd0: begin exp_rd = {31'b0, m_en}; tag_r = "R2"; end
                    2'd1: begin exp_rd = BASE + 32'(m_sel) * 32'd4096; tag_r = "R3"; end
                    2'd2: begin exp_rd = m_tab[m_sel]; tag_r = "R4"; end
                    default: begin exp_rd = '0; tag_r = "R5"; end
                endcase
            end
            cur_wr_pg = -1;
            if (reg_wr) begin
                case (reg_word)
                    2'd0: m_en = reg_wdata[0];
                    2'd1: if (longint'(reg_wdata) >= longint'(BASE) && longint'(reg_wdata) < ENDA)
                              m_sel = int'((longint'(reg_wdata) - longint'(BASE)) >>> 12);
                    2'd2: begin m_tab[m_sel] = reg_wdata & 32'hFFFF_F000; cur_wr_pg = m_sel; end
                    default: ;
                endcase
            end
            prev_wr_pg = cur_wr_pg;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 resp_valid", {31'b0, resp_valid}, {31'b0, exp_rv});
            chk({tag_l, " resp_addr"}, resp_addr, exp_ra);
            chk({tag_l, " resp_fault"}, {31'b0, resp_fault}, {31'b0, exp_rf});
            chk({tag_r, " reg_rdata"}, reg_rdata, exp_rd);
        end
    end

    task automatic drv(input logic wr, input logic rd, input logic [1:0] w, input logic [31:0] d,
                       input logic rv, input logic [31:0] ra);
        @(negedge clk);
        reg_wr <= wr; reg_rd <= rd; reg_word <= w; reg_wdata <= d;
        req_valid <= rv; req_addr <= ra;
    endtask

    task automatic idle();
        drv(0, 0, 2'd0, 32'h0, 0, 32'h0);
    endtask

    task automatic op(input logic wr, input logic rd, input logic [1:0] w, input logic [31:0] d,
                      input logic rv, input logic [31:0] ra);
        drv(wr, rd, w, d, rv, ra);
        idle();
    endtask

    initial begin
        #(20_000 * 10);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        chk("R1 resp_valid", {31'b0, resp_valid}, 32'h0);
        chk("R1 resp_fault", {31'b0, resp_fault}, 32'h0);
        chk("R1 reg_rdata", reg_rdata, 32'h0);
        // reset state of control and of a table entry
        op(0, 1, 2'd0, 32'h0, 0, 32'h0);
        chk("R1 enable off", reg_rdata, 32'h0);
        op(1, 0, 2'd1, BASE + 32'h0000_A000, 0, 32'h0);
        op(0, 1, 2'd2, 32'h0, 0, 32'h0);
        chk("R1 entry invalid", reg_rdata, 32'h0);
        // disabled: in-aperture lookup faults
        op(0, 0, 2'd0, 32'h0, 1, BASE + 32'h0000_5010);
        chk("R8 disabled fault", {31'b0, resp_fault}, 32'h1);
        // enable, map page 5
        op(1, 0, 2'd0, 32'hFFFF_FFF1, 0, 32'h0);
        op(0, 1, 2'd0, 32'h0, 0, 32'h0);
        chk("R2 enable readback", reg_rdata, 32'h1);
        op(1, 0, 2'd1, BASE + 32'h0000_5123, 0, 32'h0);
        // same-cycle write and lookup sees old entry, next cycle sees new
        drv(1, 0, 2'd2, 32'h8123_4ABC, 1, BASE + 32'h0000_5FF8);
        drv(0, 0, 2'd0, 32'h0, 1, BASE + 32'h0000_5FF8);
        chk("R11 old entry faults", {31'b0, resp_fault}, 32'h1);
        idle();
        chk("R11 new entry hit", resp_addr, 32'h0123_4FF8);
        op(0, 1, 2'd1, 32'h0, 0, 32'h0);
        chk("R3 selector readback", reg_rdata, BASE + 32'h0000_5000);
        op(0, 1, 2'd2, 32'h0, 0, 32'h0);
        chk("R4 entry readback", reg_rdata, 32'h8123_4000);
        // out-of-aperture selector writes ignored
        op(1, 0, 2'd1, BASE - 32'd4, 0, 32'h0);
        op(1, 0, 2'd1, BASE + 32'(PAGES) * 32'd4096, 0, 32'h0);
        op(0, 1, 2'd1, 32'h0, 0, 32'h0);
        chk("R3 selector kept", reg_rdata, BASE + 32'h0000_5000);
        // last page mapped, edges of aperture
        op(1, 0, 2'd1, BASE + 32'(PAGES - 1) * 32'd4096, 0, 32'h0);
        op(1, 0, 2'd2, 32'hFFFF_FFFF, 0, 32'h0);
        op(0, 0, 2'd0, 32'h0, 1, BASE + 32'(PAGES) * 32'd4096 - 32'd1);
        chk("R7 last page hit", resp_addr, 32'h7FFF_FFFF);
        op(0, 0, 2'd0, 32'h0, 1, BASE + 32'(PAGES) * 32'd4096);
        chk("R9 end faults", {31'b0, resp_fault}, 32'h1);
        op(0, 0, 2'd0, 32'h0, 1, BASE - 32'd1);
        chk("R9 below base addr", resp_addr, 32'h0);
        op(0, 0, 2'd0, 32'h0, 1, BASE + 32'h0000_7000);
        chk("R10 invalid entry", {31'b0, resp_fault}, 32'h1);
        // word 3 ignored
        op(1, 0, 2'd3, 32'hFFFF_FFFF, 0, 32'h0);
        op(0, 1, 2'd3, 32'h0, 0, 32'h0);
        chk("R5 word3 reads zero", reg_rdata, 32'h0);
        op(0, 1, 2'd0, 32'h0, 0, 32'h0);
        chk("R5 word3 write no effect", reg_rdata, 32'h1);
        // disable again: mapped page now faults
        op(1, 0, 2'd0, 32'h0, 0, 32'h0);
        op(0, 0, 2'd0, 32'h0, 1, BASE + 32'h0000_5004);
        chk("R8 mapped but off", resp_addr, 32'h0);
        // random traffic around the aperture, compared on every clock by the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] d, ra;
            logic [1:0]  w;
            logic        wr, rd, rv;
            wr = ($urandom % 4) == 0;
            rd = ($urandom % 3) == 0;
            rv = ($urandom % 2) == 0;
            w  = 2'($urandom % 4);
            ra = BASE - 32'h2000 + ($urandom % (32'(PAGES) * 32'd4096 + 32'h4000));
            if (w == 2'd0)      d = {$urandom} | 32'(($urandom % 8) != 0);
            else if (w == 2'd1) d = BASE - 32'h1000 + ($urandom % (32'(PAGES) * 32'd4096 + 32'h2000));
            else                d = $urandom;
            drv(wr, rd, w, d, rv, ra);
        end
        idle();
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule